// File: doc/BRIEF.md
# Flash Write-Status and Access-Lock Controller

This block sits between a CPU register bus and a two-bank on-chip flash array. Software starts a program, erase or protection operation by writing a start bit into a control register. From then on, hardware keeps a status word up to date. The status word holds one busy flag per bank and one global lock flag. While an operation is running, the block guards both the flash array and the other flash registers. A blocked read returns all ones and raises a one-cycle trap pulse that carries a fixed vector. A blocked write is simply dropped.

The flash sequencer reports four kinds of event: completion, suspend, resume and a supply-drop abort. Suspend frees the target bank for reading, and resume takes it again. Completion releases both the busy flag and the lock. A supply drop aborts the operation at once and leaves nothing to resume. The error register follows the sequencer's error flags, but it only samples them in cycles where no bank is busy.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset the status word reads 0x0000, and the control, address and error registers read 0x0000 with no trap.
- R2: A write of 1 to control bit 0 while the lock is clear starts an operation on the bank named by control bit 1. From the next cycle the status word shows the lock at bit 4 and the busy flag at bit 1 (bank 0) or bit 2 (bank 1). Control bits 1 and 7 read back as written, and bit 0 reads back as 0.
- R3: A start with control bit 7 set is a protection operation. It marks bank 0 busy whatever control bit 1 holds.
- R4: A read of a busy bank returns 0xFFFF on the bank data output and pulses the trap in that same cycle, with trap vector 0x009B. A write to a busy bank is not forwarded to the array. Accesses to a bank that is not busy pass straight through. When no trap is raised, the trap vector reads 0x0000.
- R5: When the sequencer reports completion, the busy flag and the lock clear in the next cycle. Completion ends the operation even while it is suspended.
- R6: A suspend clears the busy flag in the next cycle but keeps the lock set. A later resume sets the same busy flag again.
- R7: A supply-drop input aborts the operation. The next cycle shows busy and lock clear, and a later resume does nothing. The abort takes priority over a completion or a start in the same cycle.
- R8: The status word (select 0) can always be read without a trap. Writes to it have no effect.
- R9: While the lock is set, reads of the control, address and error registers (select 1, 2, 3) return 0xFFFF and pulse the trap. Writes to them, a new start included, are dropped.
- R10: The error register (select 3) loads the error-flag input at each clock edge where no busy flag was set. It holds its value while any bank is busy.
- R11: While the lock is clear, the address register (select 2) reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | Register access is a write |
| reg_sel_i | input | 2 | Register select: 0 status, 1 control, 2 address, 3 error |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, 0xFFFF when blocked |
| mem_req_i | input | 1 | Flash bank access valid |
| mem_we_i | input | 1 | Flash bank access is a write |
| mem_bank_i | input | 1 | Bank addressed by the CPU |
| mem_rdata_o | output | 16 | Bank read data to the CPU, 0xFFFF when blocked |
| arr_req_o | output | 1 | Access forwarded to the array |
| arr_we_o | output | 1 | Forwarded access is a write |
| arr_bank_o | output | 1 | Bank for the forwarded access |
| arr_rdata_i | input | 16 | Read data from the array |
| op_done_i | input | 1 | Sequencer reports completion |
| op_suspend_i | input | 1 | Sequencer reports suspend |
| op_resume_i | input | 1 | Sequencer reports resume |
| vdd_low_i | input | 1 | Internal supply below threshold |
| err_flags_i | input | 16 | Error flags from the sequencer |
| trap_o | output | 1 | One-cycle pulse on a blocked read |
| trap_vec_o | output | 16 | Trap vector while trap_o is high, else 0 |

## Verification
The sharpest collision is a bank read or register read landing in the same cycle as a completion, suspend or abort event. The access is judged against the flags as they stood before the edge, so it must trap in that cycle and pass through in the next. The bench provokes this with a directed read of the busy bank while completion is asserted. It also runs a long stretch of mixed random traffic in which events and accesses coincide freely, and a cycle-level model predicts every output. A second collision is the completion edge against error capture: the error register must still show the value it held before the operation for one cycle, and only then take up the new flags.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int DATA_W = 16;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_ERR  = 2'd3
  } reg_sel_e;

  // status word layout
  localparam int LOCK_BIT = 4;
  localparam int BUSY_LSB = 1;
  // control word layout
  localparam int START_BIT = 0;
  localparam int BANK_LSB  = 1;
  localparam int PROT_BIT  = 7;

  localparam word_t TRAP_VEC = 16'h009B;
  localparam word_t BAD_DATA = '1;
endpackage

// File: rtl/flash_op_tracker.sv
module flash_op_tracker #(
  parameter int NUM_BANKS = 2,
  parameter int PROT_BANK = 0,
  parameter int BANK_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [BANK_W-1:0]    start_bank_i,
  input  logic                 start_prot_i,
  input  logic                 done_i,
  input  logic                 susp_i,
  input  logic                 resume_i,
  input  logic                 vdd_low_i,
  output logic [NUM_BANKS-1:0] busy_o,
  output logic                 lock_o
);
  logic              active_q, susp_q;
  logic [BANK_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      susp_q   <= 1'b0;
      tgt_q    <= '0;
    end else if (vdd_low_i) begin
      active_q <= 1'b0;
      susp_q   <= 1'b0;
    end else if (active_q) begin
      if (done_i) begin
        active_q <= 1'b0;
        susp_q   <= 1'b0;
      end else if (susp_i && !susp_q) begin
        susp_q <= 1'b1;
      end else if (resume_i && susp_q) begin
        susp_q <= 1'b0;
      end
    end else if (start_i) begin
      active_q <= 1'b1;
      susp_q   <= 1'b0;
      tgt_q    <= start_prot_i ? BANK_W'(PROT_BANK) : start_bank_i;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_busy
    assign busy_o[g] = active_q && !susp_q && (tgt_q == BANK_W'(g));
  end

  assign lock_o = active_q;

  a_r2_start_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !lock_o && !vdd_low_i |=> lock_o && ($countones(busy_o) == 1));
  a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && done_i && !vdd_low_i |=> !lock_o && (busy_o == '0));
  a_r6_suspend_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != '0) && susp_i && !done_i && !vdd_low_i |=> lock_o && (busy_o == '0));
  a_r6_resume_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && (busy_o == '0) && resume_i && !done_i && !vdd_low_i |=> ($countones(busy_o) == 1));
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdd_low_i |=> !lock_o && (busy_o == '0));
  a_r4_busy_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != '0) |-> lock_o && $onehot0(busy_o));
endmodule

// File: rtl/flash_bank_gate.sv
module flash_bank_gate
  import flash_guard_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic [NUM_BANKS-1:0] busy_i,
  input  logic                 mem_req_i,
  input  logic                 mem_we_i,
  input  logic [BANK_W-1:0]    mem_bank_i,
  input  word_t                arr_rdata_i,
  output logic                 arr_req_o,
  output logic                 arr_we_o,
  output logic [BANK_W-1:0]    arr_bank_o,
  output word_t                mem_rdata_o,
  output logic                 blocked_rd_o
);
  logic sel_busy;

  always_comb begin
    sel_busy = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (mem_bank_i == BANK_W'(i)) sel_busy = busy_i[i];
  end

  assign arr_req_o    = mem_req_i && !sel_busy;
  assign arr_we_o     = mem_we_i && !sel_busy;
  assign arr_bank_o   = mem_bank_i;
  assign mem_rdata_o  = sel_busy ? BAD_DATA : arr_rdata_i;
  assign blocked_rd_o = mem_req_i && !mem_we_i && sel_busy;

  always_comb begin
    if (blocked_rd_o) a_r4_bad_data: assert (mem_rdata_o == BAD_DATA && !arr_req_o);
    if (arr_req_o)    a_r4_fwd_valid: assert (mem_req_i);
  end
endmodule

// File: rtl/flash_ctrl_regs.sv
module flash_ctrl_regs
  import flash_guard_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_sel_i,
  input  word_t                reg_wdata_i,
  output word_t                reg_rdata_o,
  input  logic                 lock_i,
  input  logic [NUM_BANKS-1:0] busy_i,
  input  word_t                err_flags_i,
  output logic                 blocked_rd_o,
  output logic                 start_o,
  output logic [BANK_W-1:0]    start_bank_o,
  output logic                 start_prot_o
);
  localparam word_t BANK_MASK = word_t'((1 << BANK_W) - 1) << BANK_LSB;
  localparam word_t CTRL_MASK = BANK_MASK | (word_t'(1) << PROT_BIT);

  reg_sel_e sel;
  word_t    ctrl_q, addr_q, err_q, stat;
  logic     wr_ok;

  assign sel   = reg_sel_e'(reg_sel_i);
  assign wr_ok = reg_req_i && reg_we_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_CTRL) ctrl_q <= reg_wdata_i & CTRL_MASK;
      if (sel == SEL_ADDR) addr_q <= reg_wdata_i;
    end
  end

  // error capture only while every bank is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            err_q <= '0;
    else if (busy_i == '0)  err_q <= err_flags_i;
  end

  assign start_o      = wr_ok && (sel == SEL_CTRL) && reg_wdata_i[START_BIT];
  assign start_bank_o = reg_wdata_i[BANK_LSB +: BANK_W];
  assign start_prot_o = reg_wdata_i[PROT_BIT];

  always_comb begin
    stat = '0;
    stat[LOCK_BIT] = lock_i;
    for (int i = 0; i < NUM_BANKS; i++) stat[BUSY_LSB + i] = busy_i[i];
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: reg_rdata_o = stat;
      SEL_CTRL: reg_rdata_o = lock_i ? BAD_DATA : ctrl_q;
      SEL_ADDR: reg_rdata_o = lock_i ? BAD_DATA : addr_q;
      SEL_ERR:  reg_rdata_o = lock_i ? BAD_DATA : err_q;
      default:  reg_rdata_o = BAD_DATA;
    endcase
  end

  assign blocked_rd_o = reg_req_i && !reg_we_i && lock_i && (sel != SEL_STAT);

  a_r10_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i != '0) |=> $stable(err_q));
  a_r9_locked_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(addr_q) && $stable(ctrl_q));
  a_r8_stat_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && (sel == SEL_STAT) |-> !blocked_rd_o);
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_BANKS = 2,  // at most 3: busy bits sit below the lock bit
  parameter int PROT_BANK = 0,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [BANK_W-1:0] mem_bank_i,
  output logic [15:0]       mem_rdata_o,
  output logic              arr_req_o,
  output logic              arr_we_o,
  output logic [BANK_W-1:0] arr_bank_o,
  input  logic [15:0]       arr_rdata_i,
  input  logic              op_done_i,
  input  logic              op_suspend_i,
  input  logic              op_resume_i,
  input  logic              vdd_low_i,
  input  logic [15:0]       err_flags_i,
  output logic              trap_o,
  output logic [15:0]       trap_vec_o
);
  logic [NUM_BANKS-1:0] busy;
  logic                 lock, start, start_prot, blk_mem, blk_reg;
  logic [BANK_W-1:0]    start_bank;

  flash_ctrl_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
    .clk_i, .rst_ni, .reg_req_i, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .lock_i(lock), .busy_i(busy), .err_flags_i,
    .blocked_rd_o(blk_reg), .start_o(start), .start_bank_o(start_bank),
    .start_prot_o(start_prot)
  );

  flash_op_tracker #(.NUM_BANKS(NUM_BANKS), .PROT_BANK(PROT_BANK), .BANK_W(BANK_W)) u_track (
    .clk_i, .rst_ni, .start_i(start), .start_bank_i(start_bank), .start_prot_i(start_prot),
    .done_i(op_done_i), .susp_i(op_suspend_i), .resume_i(op_resume_i),
    .vdd_low_i, .busy_o(busy), .lock_o(lock)
  );

  flash_bank_gate #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_gate (
    .busy_i(busy), .mem_req_i, .mem_we_i, .mem_bank_i, .arr_rdata_i,
    .arr_req_o, .arr_we_o, .arr_bank_o, .mem_rdata_o, .blocked_rd_o(blk_mem)
  );

  assign trap_o     = blk_mem || blk_reg;
  assign trap_vec_o = trap_o ? TRAP_VEC : '0;

  a_r4_trap_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (reg_req_i && !reg_we_i) || (mem_req_i && !mem_we_i));
  a_r9_trap_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> lock);
endmodule

// File: tb/flash_wr_guard_test.sv
`timescale 1ns/100ps
module flash_wr_guard_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_req = 0, reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        mem_req = 0, mem_we = 0, mem_bank = 0;
  logic [15:0] mem_rdata, arr_rdata = 16'h3C5A;
  logic        arr_req, arr_we, arr_bank;
  logic        op_done = 0, op_susp = 0, op_res = 0, vdd_low = 0;
  logic [15:0] err_flags = 0;
  logic        trap;
  logic [15:0] trap_vec;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  bit          m_active = 0, m_susp = 0;
  int          m_tgt = 0;
  logic [15:0] m_ctrl = 0, m_addr = 0, m_err = 0;

  flash_wr_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_bank_i(mem_bank),
    .mem_rdata_o(mem_rdata), .arr_req_o(arr_req), .arr_we_o(arr_we),
    .arr_bank_o(arr_bank), .arr_rdata_i(arr_rdata), .op_done_i(op_done),
    .op_suspend_i(op_susp), .op_resume_i(op_res), .vdd_low_i(vdd_low),
    .err_flags_i(err_flags), .trap_o(trap), .trap_vec_o(trap_vec)
  );

  always #2.5 clk = ~clk;

  function automatic bit mbusy(int b);
    return m_active && !m_susp && (m_tgt == b);
  endfunction

  function automatic logic [15:0] mstat();
    return {11'd0, m_active, 1'b0, mbusy(1), mbusy(0), 1'b0};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit b;
    bit t;
    logic [15:0] er;
    b = mbusy(int'(mem_bank));
    chk("R4", "mem_rdata", mem_rdata, b ? 16'hFFFF : arr_rdata);
    chk("R4", "arr_req", 16'(arr_req), 16'(mem_req && !b));
    chk("R4", "arr_we", 16'(arr_we), 16'(mem_we && !b));
    chk("R4", "arr_bank", 16'(arr_bank), 16'(mem_bank));
    case (reg_sel)
      2'd0: er = mstat();
      2'd1: er = m_active ? 16'hFFFF : m_ctrl;
      2'd2: er = m_active ? 16'hFFFF : m_addr;
      default: er = m_active ? 16'hFFFF : m_err;
    endcase
    chk(reg_sel == 0 ? "R8" : "R9", "reg_rdata", reg_rdata, er);
    t = (reg_req && !reg_we && reg_sel != 0 && m_active) || (mem_req && !mem_we && b);
    chk("R4", "trap", 16'(trap), 16'(t));
    chk("R4", "trap_vec", trap_vec, t ? 16'h009B : 16'h0000);
  endtask

  task automatic model_update();
    bit start;
    start = reg_req && reg_we && !m_active && reg_sel == 1 && reg_wdata[0];
    if (!mbusy(0) && !mbusy(1)) m_err = err_flags;
    if (reg_req && reg_we && !m_active) begin
      if (reg_sel == 1) m_ctrl = reg_wdata & 16'h0082;
      if (reg_sel == 2) m_addr = reg_wdata;
    end
    if (vdd_low) begin
      m_active = 0; m_susp = 0;
    end else if (m_active) begin
      if (op_done) begin m_active = 0; m_susp = 0; end
      else if (op_susp && !m_susp) m_susp = 1;
      else if (op_res && m_susp) m_susp = 0;
    end else if (start) begin
      m_active = 1; m_susp = 0;
      m_tgt = reg_wdata[7] ? 0 : int'(reg_wdata[1]);
    end
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_req = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    mem_req = 0; mem_we = 0; mem_bank = 0;
    op_done = 0; op_susp = 0; op_res = 0; vdd_low = 0;
  endtask

  task automatic rd(logic [1:0] s);
    idle(); reg_req = 1; reg_sel = s;
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    idle(); reg_req = 1; reg_we = 1; reg_sel = s; reg_wdata = d;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(0); #1 chk("R1", "status", reg_rdata, 16'h0000); chk("R1", "trap", 16'(trap), 0); step();
    rd(1); #1 chk("R1", "ctrl", reg_rdata, 16'h0000); step();
    rd(3); #1 chk("R1", "err", reg_rdata, 16'h0000); step();
    // R11 address register
    wr(2, 16'h1234); step();
    rd(2); #1 chk("R11", "addr", reg_rdata, 16'h1234); step();
    // R8 status is read-only
    wr(0, 16'hFFFF); step();
    rd(0); #1 chk("R8", "status after write", reg_rdata, 16'h0000); step();
    // R10 capture while idle
    idle(); err_flags = 16'h00A5; step();
    rd(3); #1 chk("R10", "err idle", reg_rdata, 16'h00A5); step();
    // R2 start on bank 1
    wr(1, 16'h0003); step();
    err_flags = 16'h0F0F;
    rd(0); #1 chk("R2", "status bank1", reg_rdata, 16'h0014); step();
    rd(1); #1 chk("R9", "ctrl locked", reg_rdata, 16'hFFFF); chk("R9", "trap", 16'(trap), 1); step();
    wr(2, 16'h5555); step();
    wr(1, 16'h0001); step();
    idle(); mem_req = 1; mem_bank = 1;
    #1 chk("R4", "busy read", mem_rdata, 16'hFFFF); chk("R4", "vec", trap_vec, 16'h009B); step();
    idle(); mem_req = 1; mem_bank = 0;
    #1 chk("R4", "free bank", mem_rdata, 16'h3C5A); chk("R4", "no trap", 16'(trap), 0); step();
    idle(); mem_req = 1; mem_we = 1; mem_bank = 1;
    #1 chk("R4", "write dropped", 16'(arr_req), 0); step();
    // R5 completion colliding with a read of the busy bank
    idle(); mem_req = 1; mem_bank = 1; op_done = 1;
    #1 chk("R5", "trap at done edge", 16'(trap), 1); step();
    idle(); mem_req = 1; mem_bank = 1;
    #1 chk("R5", "read after done", mem_rdata, 16'h3C5A); step();
    rd(0); #1 chk("R5", "status cleared", reg_rdata, 16'h0000); step();
    rd(2); #1 chk("R9", "addr kept", reg_rdata, 16'h1234); step();
    rd(1); #1 chk("R2", "ctrl readback", reg_rdata, 16'h0002); step();
    rd(3); #1 chk("R10", "err new", reg_rdata, 16'h0F0F); step();
    // R3 protection with bank field set to 1
    wr(1, 16'h0083); step();
    rd(0); #1 chk("R3", "prot bank0", reg_rdata, 16'h0012); step();
    // R6 suspend / resume
    idle(); op_susp = 1; step();
    rd(0); #1 chk("R6", "suspended", reg_rdata, 16'h0010); step();
    idle(); mem_req = 1; mem_bank = 0;
    #1 chk("R6", "read while suspended", mem_rdata, 16'h3C5A); step();
    idle(); op_res = 1; step();
    rd(0); #1 chk("R6", "resumed", reg_rdata, 16'h0012); step();
    // R7 abort beats completion; no resume afterwards
    idle(); vdd_low = 1; op_done = 1; step();
    rd(0); #1 chk("R7", "aborted", reg_rdata, 16'h0000); step();
    idle(); op_res = 1; step();
    rd(0); #1 chk("R7", "no resume", reg_rdata, 16'h0000); step();
    wr(1, 16'h0001); vdd_low = 1; step();
    rd(0); #1 chk("R7", "abort beats start", reg_rdata, 16'h0000); step();
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = $urandom_range(0, 99);
      reg_req = (r < 40); reg_we = r[0]; reg_sel = 2'($urandom_range(0, 3));
      reg_wdata = 16'($urandom);
      if ($urandom_range(0, 3) == 0) reg_wdata[0] = 1;
      mem_req = ($urandom_range(0, 1) == 1); mem_we = ($urandom_range(0, 2) == 0);
      mem_bank = 1'($urandom_range(0, 1));
      arr_rdata = 16'($urandom);
      err_flags = 16'($urandom);
      op_done = ($urandom_range(0, 19) == 0);
      op_susp = ($urandom_range(0, 9) == 0);
      op_res  = ($urandom_range(0, 9) == 0);
      vdd_low = ($urandom_range(0, 79) == 0);
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule